// File: doc/BRIEF.md
# Two-Wire Controlled Video Port Selector

This block is the control side of a switch that routes four video source ports to two sink ports. A host on a two-wire open-drain serial bus (I2C) addresses the block as a slave and writes one control byte per sink. Each control byte picks the source that feeds its sink, turns the high-speed data-lane path and the side control-channel path on or off, and chooses the output swing option. The analog path itself sits outside this block and is steered by the decoded outputs.

The slave address has five fixed bits and two bits taken from strap inputs. The straps are compared live each time an address byte finishes, so a system can move the block to another address between transactions. A read transfers exactly one byte, taken from the register that the last register-address byte pointed at. The lane enables of each sink are combined with the power-present input of the selected source, depending on a global enable input and a power-detect mode input.

Both bus lines are oversampled on the system clock through a two-flop synchronizer. START and STOP are found from SDA edges while SCL is high, and a START at any point abandons the byte in progress.

Top module: `i2c_port_selector`

## Requirements
- R1: The slave answers only the 7-bit address 0101_1,strap[1],strap[0] (the address byte is those seven bits followed by R/W in bit 0, 0 = write); it pulls SDA low in the acknowledge slot on a match, and on a mismatch it leaves SDA released for the whole transaction and changes no register.
- R2: The straps are compared at the end of each address byte and never held, so changing them between transactions moves the address that the next transaction must use.
- R3: A write is START, address byte with R/W=0, register-address byte, data byte, STOP, with each of the three bytes acknowledged; register address 1 controls sink 0 and register address 2 controls sink 1, and further bytes after the data byte are not acknowledged.
- R4: In a sink register, bits [1:0] give the source index (00 = first source through 11 = fourth), bit 2 enables the data-lane path, bit 3 enables the control-channel path and bit 4 drives the swing option; bits [7:5] reach no output but read back as written.
- R5: A sink register changes only when the data byte of a write to its own address completes.
- R6: Register addresses other than 1 and 2 are acknowledged, writes to them change nothing, and reads from them return 0x00.
- R7: A read (address byte with R/W=1, usually after a repeated START) returns one byte, the register selected by the last register-address byte; after that byte and its acknowledge slot the slave keeps SDA released until the next START or STOP, whatever the master answered.
- R8: When the global enable input or the power-detect mode input is high, each sink's data-lane and control-channel enables equal the register bit ANDed with the power-present input of the source that sink selects; when both are low they equal the register bits alone.
- R9: The slave only starts pulling SDA low while SCL is low.
- R10: A START, including one in the middle of a byte, discards the partial byte and begins a new address phase; a STOP releases SDA and returns the slave to idle.
- R11: After reset all sink registers and the register pointer are 0x00, so every sink selects the first source with both paths off and swing 0, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| strap_i | input | 2 | Address strap bits, [1] above [0] |
| glob_en_i | input | 1 | Global enable input for power gating |
| pd_mode_i | input | 1 | Power-detect mode input for power gating |
| pwr_present_i | input | NSRC (4) | Per-source power-present flags |
| sink_sel_o | output | NSINK*2 (4) | Selected source index per sink, sink 0 in the low bits |
| sink_data_en_o | output | NSINK (2) | Data-lane path enable per sink |
| sink_ctrl_en_o | output | NSINK (2) | Control-channel path enable per sink |
| sink_swing_o | output | NSINK (2) | Swing option per sink |

## Verification
Writes and read-backs use random register addresses, including the unmapped 0 and 3, and random data with random reserved bits, which separates a wrong field slice from a wrong register decode and shows whether ignored addresses leak into the map. Directed transactions with the strap pattern changed between them, a strap pattern one bit away from the live one, a read that the master tries to stretch to two bytes and a START inserted after three address bits tell a latched or mis-compared address from a live one and a continuing read from a single-byte one. The power combining is tried over random mixes of global enable, power-detect mode and power-present bits against several source selections, which distinguishes gating by the selected source from gating by the sink's own index or by no source at all.

// File: rtl/i2c_port_selector_pkg.sv
package i2c_port_selector_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CNT_W   = $clog2(BYTE_W);
  localparam int unsigned STRAP_W = 2;
  localparam logic [6-STRAP_W:0] DEV_ID_HI = 5'b01011;

  // Control byte field positions
  localparam int unsigned FLD_SEL_LSB = 0;
  localparam int unsigned FLD_DATA_EN = 2;
  localparam int unsigned FLD_CTRL_EN = 3;
  localparam int unsigned FLD_SWING   = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_IGNORE
  } xfer_state_t;

endpackage

// File: rtl/i2c_port_selector_line_sync.sv
module i2c_port_selector_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_prev  <= 1'b1;
      sda_prev  <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
      scl_prev  <= scl_chain[SYNC_STAGES-1];
      sda_prev  <= sda_chain[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_chain[SYNC_STAGES-1];
  assign sda_o      = sda_chain[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/i2c_port_selector_xfer.sv
module i2c_port_selector_xfer
  import i2c_port_selector_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               ev_start,
  input  logic               ev_stop,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_oe_o,
  output logic               wr_en_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic [BYTE_W-1:0]  ptr_o
);

  xfer_state_t       state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              full_q, full_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] ptr_q, ptr_n;
  logic              rw_q, rw_n;
  logic              wr_en;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    full_n  = full_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    rw_n    = rw_q;
    wr_en   = 1'b0;
    if (ev_stop) begin
      state_n = ST_IDLE;
    end else if (ev_start) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      full_n  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_REG, ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(BYTE_W-1)) full_n = 1'b1;
          end else if (scl_fall && full_q) begin
            full_n = 1'b0;
            if (state_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == {DEV_ID_HI, strap_i}) begin
                rw_n    = sh_q[0];
                state_n = ST_ADDR_ACK;
              end else begin
                state_n = ST_IGNORE;
              end
            end else if (state_q == ST_REG) begin
              ptr_n   = sh_q;
              state_n = ST_REG_ACK;
            end else begin
              wr_en   = 1'b1;
              state_n = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n  = '0;
            full_n = 1'b0;
            if (rw_q) begin
              state_n = ST_RDATA;
              sh_n    = rd_data_i;
            end else begin
              state_n = ST_REG;
            end
          end
        end
        ST_REG_ACK: begin
          if (scl_fall) begin
            cnt_n   = '0;
            full_n  = 1'b0;
            state_n = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(BYTE_W-1)) full_n = 1'b1;
          end else if (scl_fall) begin
            if (full_q) begin
              full_n  = 1'b0;
              state_n = ST_RDATA_ACK;
            end else begin
              sh_n = {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_WDATA_ACK, ST_RDATA_ACK: begin
          if (scl_fall) state_n = ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      full_q  <= full_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      rw_q    <= rw_n;
    end
  end

  assign sda_oe_o  = (state_q == ST_ADDR_ACK) || (state_q == ST_REG_ACK) ||
                     (state_q == ST_WDATA_ACK) ||
                     ((state_q == ST_RDATA) && !sh_q[BYTE_W-1]);
  assign wr_en_o   = wr_en;
  assign wr_data_o = sh_q;
  assign ptr_o     = ptr_q;

endmodule

// File: rtl/i2c_port_selector_regs.sv
module i2c_port_selector_regs
  import i2c_port_selector_pkg::*;
#(
  parameter int unsigned NSINK = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [BYTE_W-1:0]       addr_i,
  input  logic [BYTE_W-1:0]       wr_data_i,
  output logic [BYTE_W-1:0]       rd_data_o,
  output logic [NSINK*BYTE_W-1:0] regs_o
);

  for (genvar g = 0; g < NSINK; g++) begin : g_sink
    logic [BYTE_W-1:0] ctl_q;
    logic              hit;
    assign hit = wr_en_i && (addr_i == BYTE_W'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctl_q <= '0;
      else if (hit) ctl_q <= wr_data_i;
    end
    assign regs_o[g*BYTE_W +: BYTE_W] = ctl_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < NSINK; s++) begin
      if (addr_i == BYTE_W'(s + 1)) rd_data_o = regs_o[s*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/i2c_port_selector_enable_mix.sv
module i2c_port_selector_enable_mix
  import i2c_port_selector_pkg::*;
#(
  parameter int unsigned NSINK = 2,
  parameter int unsigned NSRC  = 4,
  localparam int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic [NSINK*BYTE_W-1:0] regs_i,
  input  logic                    glob_en_i,
  input  logic                    pd_mode_i,
  input  logic [NSRC-1:0]         pwr_present_i,
  output logic [NSINK*SEL_W-1:0]  sel_o,
  output logic [NSINK-1:0]        data_en_o,
  output logic [NSINK-1:0]        ctrl_en_o,
  output logic [NSINK-1:0]        swing_o
);

  logic gate_on;
  assign gate_on = glob_en_i | pd_mode_i;

  for (genvar g = 0; g < NSINK; g++) begin : g_sink
    logic [BYTE_W-1:0] ctl;
    logic [SEL_W-1:0]  sel;
    logic              src_pwr;
    logic              unused_rsvd;
    assign ctl         = regs_i[g*BYTE_W +: BYTE_W];
    assign sel         = ctl[FLD_SEL_LSB +: SEL_W];
    assign src_pwr     = gate_on ? pwr_present_i[sel] : 1'b1;
    assign unused_rsvd = ^ctl[BYTE_W-1:FLD_SWING+1];
    assign sel_o[g*SEL_W +: SEL_W] = sel;
    assign data_en_o[g] = ctl[FLD_DATA_EN] & src_pwr;
    assign ctrl_en_o[g] = ctl[FLD_CTRL_EN] & src_pwr;
    assign swing_o[g]   = ctl[FLD_SWING];
  end

endmodule

// File: rtl/i2c_port_selector.sv
module i2c_port_selector
  import i2c_port_selector_pkg::*;
#(
  parameter int unsigned NSINK = 2,
  parameter int unsigned NSRC  = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic [STRAP_W-1:0]     strap_i,
  input  logic                   glob_en_i,
  input  logic                   pd_mode_i,
  input  logic [NSRC-1:0]        pwr_present_i,
  output logic [NSINK*SEL_W-1:0] sink_sel_o,
  output logic [NSINK-1:0]       sink_data_en_o,
  output logic [NSINK-1:0]       sink_ctrl_en_o,
  output logic [NSINK-1:0]       sink_swing_o
);

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
  logic wr_en;
  logic [BYTE_W-1:0] wr_data, wr_ptr, rd_data;
  logic [NSINK*BYTE_W-1:0] regs_flat;

  i2c_port_selector_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_lvl), .sda_o(sda_lvl), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(ev_start), .stop_o(ev_stop)
  );

  i2c_port_selector_xfer u_xfer (
    .clk(clk), .rst_n(rst_core_n), .sda_s(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop), .strap_i(strap_i),
    .rd_data_i(rd_data), .sda_oe_o(sda_oe_o), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .ptr_o(wr_ptr)
  );

  i2c_port_selector_regs #(.NSINK(NSINK)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en_i(wr_en), .addr_i(wr_ptr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .regs_o(regs_flat)
  );

  i2c_port_selector_enable_mix #(.NSINK(NSINK), .NSRC(NSRC)) u_mix (
    .regs_i(regs_flat), .glob_en_i(glob_en_i), .pd_mode_i(pd_mode_i),
    .pwr_present_i(pwr_present_i), .sel_o(sink_sel_o),
    .data_en_o(sink_data_en_o), .ctrl_en_o(sink_ctrl_en_o),
    .swing_o(sink_swing_o)
  );

endmodule

// File: rtl/i2c_port_selector_chk.sv
module i2c_port_selector_chk
  import i2c_port_selector_pkg::*;
#(
  parameter int unsigned NSINK = 2,
  parameter int unsigned NSRC  = 4,
  localparam int unsigned SEL_W = $clog2(NSRC)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    scl_lvl,
  input logic                    ev_start,
  input logic                    ev_stop,
  input logic                    wr_en,
  input logic [BYTE_W-1:0]       wr_ptr,
  input logic [NSINK*BYTE_W-1:0] regs_flat,
  input logic                    sda_oe_o,
  input logic                    glob_en_i,
  input logic [NSRC-1:0]         pwr_present_i,
  input logic [NSINK*SEL_W-1:0]  sink_sel_o,
  input logic [NSINK-1:0]        sink_data_en_o,
  input logic [NSINK-1:0]        sink_ctrl_en_o
);

  a_r9_pull_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_lvl);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe_o);

  a_r10_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe_o);

  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

  a_r6_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_ptr != BYTE_W'(1)) && (wr_ptr != BYTE_W'(2))) |=> $stable(regs_flat));

  for (genvar g = 0; g < NSINK; g++) begin : g_pwr
    a_r8_unpowered_source_off: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_en_i && !pwr_present_i[sink_sel_o[g*SEL_W +: SEL_W]])
        |-> (!sink_data_en_o[g] && !sink_ctrl_en_o[g]));
  end

endmodule

bind i2c_port_selector i2c_port_selector_chk #(.NSINK(NSINK), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .ev_start(ev_start),
  .ev_stop(ev_stop), .wr_en(wr_en), .wr_ptr(wr_ptr), .regs_flat(regs_flat),
  .sda_oe_o(sda_oe_o), .glob_en_i(glob_en_i), .pwr_present_i(pwr_present_i),
  .sink_sel_o(sink_sel_o), .sink_data_en_o(sink_data_en_o),
  .sink_ctrl_en_o(sink_ctrl_en_o)
);

// File: tb/i2c_port_selector_tb.sv
module i2c_port_selector_tb;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [1:0] strap = 2'b00;
  logic glob_en = 1'b0;
  logic pd_mode = 1'b0;
  logic [3:0] pwr = 4'b0000;
  logic [3:0] sel;
  logic [1:0] den, cen, swg;

  int n_cmp = 0;
  int n_err = 0;
  logic [7:0] exp_reg [2];

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_port_selector u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .glob_en_i(glob_en),
    .pd_mode_i(pd_mode), .pwr_present_i(pwr), .sink_sel_o(sel),
    .sink_data_en_o(den), .sink_ctrl_en_o(cen), .sink_swing_o(swg)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] st, input logic rd);
    return {5'b01011, st, rd};
  endfunction

  function automatic logic exp_en(input logic bit_v, input logic g, input logic p,
                                  input logic src_pwr);
    return (g | p) ? (bit_v & src_pwr) : bit_v;
  endfunction

  // R9 monitor: pull-down must begin only while SCL is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl) begin
      n_cmp++;
      n_err++;
      $display("FAIL R9: SDA pulled while SCL high, actual 1 expected 0");
    end
    oe_prev <= sda_oe;
  end

  task automatic wait_q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wait_q();
    scl = 1'b1; wait_q(); wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wait_q();
    scl = 1'b1; wait_q();
    b = sda_line; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v);
      b[i] = v;
    end
    bit_out(~m_ack);
  endtask

  task automatic reg_write(input logic [1:0] st, input logic [7:0] ra,
                           input logic [7:0] d, output logic [2:0] acks);
    logic a;
    bus_start();
    send_byte(addr_byte(st, 1'b0), a); acks[2] = a;
    send_byte(ra, a); acks[1] = a;
    send_byte(d, a); acks[0] = a;
    bus_stop();
  endtask

  task automatic reg_read(input logic [1:0] st, input logic [7:0] ra,
                          output logic [7:0] d);
    logic a;
    bus_start();
    send_byte(addr_byte(st, 1'b0), a);
    send_byte(ra, a);
    bus_start();
    send_byte(addr_byte(st, 1'b1), a);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic check_outputs(input string req);
    for (int s = 0; s < 2; s++) begin
      logic [1:0] es;
      es = exp_reg[s][1:0];
      check({req, " sel"}, int'(sel[s*2 +: 2]), int'(es));
      check({req, " data_en"}, int'(den[s]),
            int'(exp_en(exp_reg[s][2], glob_en, pd_mode, pwr[es])));
      check({req, " ctrl_en"}, int'(cen[s]),
            int'(exp_en(exp_reg[s][3], glob_en, pd_mode, pwr[es])));
      check({req, " swing"}, int'(swg[s]), int'(exp_reg[s][4]));
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] rd;
    logic a;
    void'($urandom(32'h5EED_0C41));
    exp_reg[0] = 8'h00;
    exp_reg[1] = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #1;

    // R11: reset state
    check("R11 sda released", int'(sda_oe), 0);
    check_outputs("R11");
    reg_read(2'b00, 8'h01, rd);
    check("R11 reg1 reset value", int'(rd), 0);

    // R1 R3 R4: basic write to sink 0
    reg_write(2'b00, 8'h01, 8'h0E, acks);
    check("R1 R3 write acks", int'(acks), 7);
    exp_reg[0] = 8'h0E;
    check_outputs("R4 after write");
    reg_read(2'b00, 8'h01, rd);
    check("R7 readback reg1", int'(rd), 8'h0E);

    // R1 R5: wrong address ignored
    reg_write(2'b01, 8'h01, 8'h13, acks);
    check("R1 mismatch no ack", int'(acks), 0);
    check_outputs("R5 mismatch no change");

    // R2: live straps
    strap = 2'b10;
    reg_write(2'b00, 8'h02, 8'h1B, acks);
    check("R2 old address rejected", int'(acks), 0);
    reg_write(2'b10, 8'h02, 8'h1B, acks);
    check("R2 new address accepted", int'(acks), 7);
    exp_reg[1] = 8'h1B;
    check_outputs("R2 R3 sink1");

    // R4: reserved bits reach no output but read back
    reg_write(2'b10, 8'h02, 8'hE5, acks);
    exp_reg[1] = 8'hE5;
    check_outputs("R4 reserved bits");
    reg_read(2'b10, 8'h02, rd);
    check("R4 reserved readback", int'(rd), 8'hE5);

    // R6: unmapped addresses
    reg_write(2'b10, 8'h03, 8'hFF, acks);
    check("R6 unmapped write acked", int'(acks), 7);
    check_outputs("R6 unmapped write ignored");
    reg_read(2'b10, 8'h00, rd);
    check("R6 unmapped read zero", int'(rd), 0);

    // R7: single-byte read, second byte not driven
    bus_start();
    send_byte(addr_byte(2'b10, 1'b0), a);
    send_byte(8'h01, a);
    bus_start();
    send_byte(addr_byte(2'b10, 1'b1), a);
    recv_byte(1'b1, rd);
    check("R7 first read byte", int'(rd), 8'h0E);
    recv_byte(1'b0, rd);
    check("R7 second byte released", int'(rd), 8'hFF);
    bus_stop();

    // R10: START in mid-byte restarts address phase
    bus_start();
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    bus_start();
    send_byte(addr_byte(2'b10, 1'b0), a); acks[2] = a;
    send_byte(8'h01, a); acks[1] = a;
    send_byte(8'h07, a); acks[0] = a;
    bus_stop();
    check("R10 restart acks", int'(acks), 7);
    exp_reg[0] = 8'h07;
    check_outputs("R10 restart write");

    // R3: byte after data byte not acknowledged
    bus_start();
    send_byte(addr_byte(2'b10, 1'b0), a);
    send_byte(8'h02, a);
    send_byte(8'h0C, a);
    send_byte(8'h10, a);
    check("R3 extra byte not acked", int'(a), 0);
    bus_stop();
    exp_reg[1] = 8'h0C;
    check_outputs("R3 extra byte ignored");

    // R8: enable combining sweep
    for (int i = 0; i < 40; i++) begin
      glob_en = 1'($urandom);
      pd_mode = 1'($urandom);
      pwr     = 4'($urandom);
      #20;
      check_outputs("R8 combine");
    end

    // R4 R6 R7: random writes and readbacks
    for (int i = 0; i < 20; i++) begin
      logic [7:0] ra, d;
      ra = 8'($urandom_range(0, 3));
      d  = 8'($urandom);
      strap = 2'($urandom);
      pwr = 4'($urandom);
      glob_en = 1'($urandom);
      pd_mode = 1'($urandom);
      reg_write(strap, ra, d, acks);
      check("R3 random acks", int'(acks), 7);
      if (ra == 8'h01) exp_reg[0] = d;
      if (ra == 8'h02) exp_reg[1] = d;
      check_outputs("R4 random");
      reg_read(strap, ra, rd);
      check("R7 random readback", int'(rd),
            (ra == 8'h01) ? int'(exp_reg[0]) : (ra == 8'h02) ? int'(exp_reg[1]) : 0);
    end

    summary();
  end

endmodule